// File: doc/BRIEF.md
# Filtered Uncore Event Counter

This block counts one chosen kind of event seen by a shared cache or interconnect agent. At most one event arrives per cycle. Each event carries its code, the index of the requesting core or thread, a request kind, a data-source code, an 11-bit source cluster ID, an 11-bit target cluster ID, and a flag for the ring channel it used. An ID holds a 6-bit super-cluster number in bits 10:5 and a 5-bit cluster number in bits 4:0.

Software selects an event code and may switch on any mix of six qualifiers: a core bitmap, a request-kind match, a data-source match, a masked source-ID match, a masked target-ID match and a ring-channel select. An event is counted only when its code matches and every qualifier that is switched on accepts it. A small register port reads the counter back and clears it. When the counter wraps, a sticky flag is set and an interrupt is raised until software clears the flag.

Top module: `evt_filter_counter`

## Requirements
- R1: After reset the counter reads 0, the overflow flag (register 6, bit 0) reads 0 and `irq` is low.
- R2: With every qualifier switched off, each cycle with `ev_valid` high and `ev_code` equal to the selected code (register 0, bits 7:0) adds one to the counter, visible from the next cycle on; events with any other code leave it unchanged.
- R3: Core qualifier (enable at register 0 bit 16, bitmap at register 1 bits 7:0): an event passes only if the bitmap bit indexed by `ev_core` is 1.
- R4: Request qualifier (enable at register 0 bit 17, code at register 1 bits 18:16): code 3'b100 accepts reads (`ev_req`=0), 3'b101 writes (1), 3'b110 atomic stores (2), 3'b111 atomic non-stores (3); any code with bit 2 clear accepts no event. With the enable clear all kinds pass.
- R5: Data-source qualifier (enable at register 0 bit 18, code at register 1 bits 28:24): an event passes only if `ev_dsrc` equals the code in all 5 bits, e.g. 5'b01110 accepts local memory but not 5'b01111.
- R6: Source-ID qualifier (enable at register 0 bit 19; register 2 holds the match value in bits 10:0 and a mask in bits 26:16): an event passes if `ev_sid` equals the value on every bit whose mask bit is 0; bits with mask 1 are not compared.
- R7: Target-ID qualifier (enable at register 0 bit 20; register 3 laid out like register 2) applies the same masked comparison to `ev_tid`.
- R8: Channel qualifier (enable at register 0 bit 21, select at register 1 bits 31:30): select 2'b01 or 2'b11 accepts only extended-ring events (`ev_ext`=1), 2'b10 only normal-ring events (`ev_ext`=0), 2'b00 accepts both.
- R9: The channel qualifier applies only when the selected code lies from 0x47 to 0x59 inclusive; for any other code it has no effect.
- R10: An event is counted only when the code matches and all switched-on qualifiers accept it at once; with `ev_valid` low nothing is counted.
- R11: Register 4 reads counter bits 31:0 and register 5 bits 47:32 (zero above); writing register 4 clears the counter, and a clear in the same cycle as a qualifying event leaves 0.
- R12: When the counter wraps from all ones to zero, the overflow flag sets and `irq` rises; both stay set while counting continues until a write to register 6 with bit 0 set clears them; a wrap in the same cycle as that write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An event is present this cycle |
| ev_code | input | 8 | Event code |
| ev_core | input | 3 | Requesting core/thread index in the cluster |
| ev_req | input | 2 | Request kind: 0 read, 1 write, 2 atomic store, 3 atomic non-store |
| ev_dsrc | input | 5 | Data-source code |
| ev_sid | input | 11 | Source cluster ID |
| ev_tid | input | 11 | Target cluster ID |
| ev_ext | input | 1 | 1 if the event used the extended ring, 0 for the normal ring |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Overflow interrupt, level |

## Verification
Each qualifier is driven alone with a mix of events on both sides of its match, so a count that is too high shows a qualifier that lets through what it should reject, and one that is too low shows a wrong encoding. The request qualifier is also tried with a reserved code and with its enable clear. The channel qualifier is tried at codes 0x47 and 0x59 and just outside them, which separates an off-by-one range from a correct one. A combined case in which each event fails exactly one of two qualifiers tells an AND from an OR. A narrow second instance is run through a wrap to check the sticky flag, the interrupt and its clear.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int EV_W   = 8;
    localparam int N_CORE = 8;
    localparam int CORE_W = $clog2(N_CORE);
    localparam int REQ_W  = 3;
    localparam int DS_W   = 5;
    localparam int ID_W   = 11;
    localparam int CH_W   = 2;
    localparam int N_IDF  = 2;
    localparam int RW     = 32;

    localparam logic [EV_W-1:0] CHAN_CODE_LO = 8'h47;
    localparam logic [EV_W-1:0] CHAN_CODE_HI = 8'h59;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_FILT  = 3'd1;
    localparam logic [2:0] A_SID   = 3'd2;
    localparam logic [2:0] A_TID   = 3'd3;
    localparam logic [2:0] A_CNTLO = 3'd4;
    localparam logic [2:0] A_CNTHI = 3'd5;
    localparam logic [2:0] A_STAT  = 3'd6;

    typedef enum logic [1:0] {
        RK_READ     = 2'd0,
        RK_WRITE    = 2'd1,
        RK_ATOM_ST  = 2'd2,
        RK_ATOM_NST = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic [EV_W-1:0]   code;
        logic [CORE_W-1:0] core;
        req_kind_e         kind;
        logic [DS_W-1:0]   dsrc;
        logic [ID_W-1:0]   sid;
        logic [ID_W-1:0]   tid;
        logic              ext;
    } evt_t;

    typedef struct packed {
        logic [EV_W-1:0]   code;
        logic              core_en;
        logic              req_en;
        logic              ds_en;
        logic              sid_en;
        logic              tid_en;
        logic              chan_en;
        logic [N_CORE-1:0] core_map;
        logic [REQ_W-1:0]  req_sel;
        logic [DS_W-1:0]   ds_sel;
        logic [ID_W-1:0]   sid_cmd;
        logic [ID_W-1:0]   sid_msk;
        logic [ID_W-1:0]   tid_cmd;
        logic [ID_W-1:0]   tid_msk;
        logic [CH_W-1:0]   chan_sel;
    } cfg_t;

    function automatic logic id_match(input logic [ID_W-1:0] id,
                                      input logic [ID_W-1:0] cmd,
                                      input logic [ID_W-1:0] msk);
        return &((id ~^ cmd) | msk);
    endfunction

    function automatic logic req_match(input logic [REQ_W-1:0] sel,
                                       input req_kind_e kind);
        return sel[2] && (sel[1:0] == kind);
    endfunction

    function automatic logic chan_match(input logic [CH_W-1:0] sel,
                                        input logic ext);
        logic ok;
        case (sel)
            2'b00:   ok = 1'b1;
            2'b10:   ok = !ext;
            default: ok = ext;
        endcase
        return ok;
    endfunction

    function automatic logic chan_applies(input logic [EV_W-1:0] code);
        return (code >= CHAN_CODE_LO) && (code <= CHAN_CODE_HI);
    endfunction

endpackage

// File: rtl/evc_filter.sv
module evc_filter
    import evc_pkg::*;
(
    input  logic ev_valid,
    input  evt_t evt,
    input  cfg_t cfg,
    output logic hit
);
    logic [N_IDF-1:0]  idf_en;
    logic [ID_W-1:0]   idf_val [N_IDF];
    logic [ID_W-1:0]   idf_cmd [N_IDF];
    logic [ID_W-1:0]   idf_msk [N_IDF];
    logic [N_IDF-1:0]  idf_pass;

    assign idf_en     = {cfg.tid_en, cfg.sid_en};
    assign idf_val[0] = evt.sid;
    assign idf_cmd[0] = cfg.sid_cmd;
    assign idf_msk[0] = cfg.sid_msk;
    assign idf_val[1] = evt.tid;
    assign idf_cmd[1] = cfg.tid_cmd;
    assign idf_msk[1] = cfg.tid_msk;

    for (genvar g = 0; g < N_IDF; g++) begin : g_idf
        assign idf_pass[g] = !idf_en[g] ||
                             id_match(idf_val[g], idf_cmd[g], idf_msk[g]);
    end

    logic code_ok, core_ok, req_ok, ds_ok, chan_ok;

    always_comb begin
        code_ok = (evt.code == cfg.code);
        core_ok = !cfg.core_en || cfg.core_map[evt.core];
        req_ok  = !cfg.req_en  || req_match(cfg.req_sel, evt.kind);
        ds_ok   = !cfg.ds_en   || (evt.dsrc == cfg.ds_sel);
        chan_ok = !cfg.chan_en || !chan_applies(cfg.code) ||
                  chan_match(cfg.chan_sel, evt.ext);
        hit     = ev_valid && code_ok && core_ok && req_ok && ds_ok &&
                  chan_ok && (&idf_pass);
    end

endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             clr_cnt,
    input  logic             clr_ovf,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic wrap;
    assign wrap = hit && !clr_cnt && (&cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (clr_cnt)  cnt <= '0;
            else if (hit) cnt <= cnt + 1'b1;

            if (wrap)         ovf <= 1'b1;
            else if (clr_ovf) ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/evc_regs.sv
module evc_regs
    import evc_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [RW-1:0]    wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ovf,
    output cfg_t             cfg,
    output logic             clr_cnt,
    output logic             clr_ovf,
    output logic [RW-1:0]    rdata
);
    localparam int EXT_W = 2 * RW;

    logic [EXT_W-1:0] cnt_ext;
    logic             unused_wdata;

    assign cnt_ext      = EXT_W'(cnt);
    assign unused_wdata = ^wdata;
    assign clr_cnt      = we && (addr == A_CNTLO);
    assign clr_ovf      = we && (addr == A_STAT) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (addr)
                A_CTRL: begin
                    cfg.code    <= wdata[EV_W-1:0];
                    cfg.core_en <= wdata[16];
                    cfg.req_en  <= wdata[17];
                    cfg.ds_en   <= wdata[18];
                    cfg.sid_en  <= wdata[19];
                    cfg.tid_en  <= wdata[20];
                    cfg.chan_en <= wdata[21];
                end
                A_FILT: begin
                    cfg.core_map <= wdata[N_CORE-1:0];
                    cfg.req_sel  <= wdata[18:16];
                    cfg.ds_sel   <= wdata[28:24];
                    cfg.chan_sel <= wdata[31:30];
                end
                A_SID: begin
                    cfg.sid_cmd <= wdata[ID_W-1:0];
                    cfg.sid_msk <= wdata[16+ID_W-1:16];
                end
                A_TID: begin
                    cfg.tid_cmd <= wdata[ID_W-1:0];
                    cfg.tid_msk <= wdata[16+ID_W-1:16];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[EV_W-1:0] = cfg.code;
                rdata[21:16]    = {cfg.chan_en, cfg.tid_en, cfg.sid_en,
                                   cfg.ds_en, cfg.req_en, cfg.core_en};
            end
            A_FILT: begin
                rdata[N_CORE-1:0] = cfg.core_map;
                rdata[18:16]      = cfg.req_sel;
                rdata[28:24]      = cfg.ds_sel;
                rdata[31:30]      = cfg.chan_sel;
            end
            A_SID: begin
                rdata[ID_W-1:0]       = cfg.sid_cmd;
                rdata[16+ID_W-1:16]   = cfg.sid_msk;
            end
            A_TID: begin
                rdata[ID_W-1:0]       = cfg.tid_cmd;
                rdata[16+ID_W-1:16]   = cfg.tid_msk;
            end
            A_CNTLO: rdata = cnt_ext[RW-1:0];
            A_CNTHI: rdata = cnt_ext[EXT_W-1:RW];
            A_STAT:  rdata[0] = ovf;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_filter_counter.sv
module evt_filter_counter
    import evc_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [EV_W-1:0]   ev_code,
    input  logic [CORE_W-1:0] ev_core,
    input  logic [1:0]        ev_req,
    input  logic [DS_W-1:0]   ev_dsrc,
    input  logic [ID_W-1:0]   ev_sid,
    input  logic [ID_W-1:0]   ev_tid,
    input  logic              ev_ext,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [RW-1:0]     reg_wdata,
    output logic [RW-1:0]     reg_rdata,
    output logic              irq
);
    evt_t             evt;
    cfg_t             cfg;
    logic             hit;
    logic             clr_cnt;
    logic             clr_ovf;
    logic [CNT_W-1:0] cnt;
    logic             ovf;

    assign evt = '{code: ev_code, core: ev_core, kind: req_kind_e'(ev_req),
                   dsrc: ev_dsrc, sid: ev_sid, tid: ev_tid, ext: ev_ext};

    evc_filter u_filter (
        .ev_valid (ev_valid),
        .evt      (evt),
        .cfg      (cfg),
        .hit      (hit)
    );

    evc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .clr_cnt (clr_cnt),
        .clr_ovf (clr_ovf),
        .cnt     (cnt),
        .ovf     (ovf)
    );

    evc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .cnt     (cnt),
        .ovf     (ovf),
        .cfg     (cfg),
        .clr_cnt (clr_cnt),
        .clr_ovf (clr_ovf),
        .rdata   (reg_rdata)
    );

    assign irq = ovf;

endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_valid,
    input logic             hit,
    input logic             clr_cnt,
    input logic             clr_ovf,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf,
    input logic             irq
);
    // R2: a qualifying event advances the counter by one in the next cycle
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        hit && !clr_cnt |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R2: no qualifying event, no clear -> counter holds
    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        !hit && !clr_cnt |=> cnt == $past(cnt));

    // R10: no valid input never yields a count qualifier
    a_r10_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !ev_valid |-> !hit);

    // R11: clear wins over a simultaneous event
    a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr_cnt |=> cnt == '0);

    // R12: flag rises only on a wrap to zero
    a_r12_set_on_wrap: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> (cnt == '0) && $past(hit));

    // R12: flag is sticky until cleared
    a_r12_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf && !clr_ovf |=> ovf);

    // R12: clear without a simultaneous wrap drops the flag and interrupt
    a_r12_w1c: assert property (@(posedge clk) disable iff (rst)
        clr_ovf && !(hit && !clr_cnt && (&cnt)) |=> !ovf && !irq);

    // R12: interrupt and flag rise together
    a_r12_irq_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $rose(ovf));

endmodule

bind evt_filter_counter evc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev_valid (ev_valid),
    .hit      (hit),
    .clr_cnt  (clr_cnt),
    .clr_ovf  (clr_ovf),
    .cnt      (cnt),
    .ovf      (ovf),
    .irq      (irq)
);

// File: tb/tb_evt_filter_counter.sv
module tb_evt_filter_counter;
    import evc_pkg::*;

    localparam int SMALL_W = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ev_valid = 1'b0;
    logic [EV_W-1:0]   ev_code = '0;
    logic [CORE_W-1:0] ev_core = '0;
    logic [1:0]        ev_req = '0;
    logic [DS_W-1:0]   ev_dsrc = '0;
    logic [ID_W-1:0]   ev_sid = '0;
    logic [ID_W-1:0]   ev_tid = '0;
    logic              ev_ext = 1'b0;
    logic              reg_we = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [RW-1:0]     reg_wdata = '0;
    logic [RW-1:0]     reg_rdata, reg_rdata_s;
    logic              irq, irq_s;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    evt_filter_counter dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_code),
        .ev_core(ev_core), .ev_req(ev_req), .ev_dsrc(ev_dsrc),
        .ev_sid(ev_sid), .ev_tid(ev_tid), .ev_ext(ev_ext),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    evt_filter_counter #(.CNT_W(SMALL_W)) dut_small (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_code),
        .ev_core(ev_core), .ev_req(ev_req), .ev_dsrc(ev_dsrc),
        .ev_sid(ev_sid), .ev_tid(ev_tid), .ev_ext(ev_ext),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata_s), .irq(irq_s)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [RW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [RW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_s(input logic [2:0] a, output logic [RW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata_s;
    endtask

    function automatic logic [RW-1:0] mk_ctrl(input logic [7:0] code,
                                              input logic [5:0] en);
        return {10'd0, en, 8'd0, code};
    endfunction

    function automatic logic [RW-1:0] mk_filt(input logic [7:0] map,
            input logic [2:0] rq, input logic [4:0] ds, input logic [1:0] ch);
        return {ch, 1'b0, ds, 5'd0, rq, 8'd0, map};
    endfunction

    task automatic setup(input logic [RW-1:0] c, input logic [RW-1:0] f,
                         input logic [RW-1:0] s, input logic [RW-1:0] t);
        wr(A_CTRL, c); wr(A_FILT, f); wr(A_SID, s); wr(A_TID, t);
        wr(A_CNTLO, 0);
    endtask

    task automatic send(input logic [7:0] code, input logic [2:0] core,
                        input logic [1:0] rq, input logic [4:0] ds,
                        input logic [10:0] sid, input logic [10:0] tid,
                        input logic ext);
        @(negedge clk);
        ev_valid = 1'b1; ev_code = code; ev_core = core; ev_req = rq;
        ev_dsrc = ds; ev_sid = sid; ev_tid = tid; ev_ext = ext;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic expect_cnt(input string req, input longint exp);
        logic [RW-1:0] v;
        rd(A_CNTLO, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset;
        logic [RW-1:0] v;
        rd(A_CNTLO, v); chk("R1 count lo", v, 0);
        rd(A_CNTHI, v); chk("R1 count hi", v, 0);
        rd(A_STAT, v);  chk("R1 overflow flag", v, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_plain;
        setup(mk_ctrl(8'h12, 6'b0), 0, 0, 0);
        send(8'h12, 3'd5, 2'd0, 5'd3, 11'h7FF, 11'h001, 1'b1);
        expect_cnt("R2 one event next cycle", 1);
        send(8'h12, 3'd0, 2'd3, 5'd0, 11'h000, 11'h3A0, 1'b0);
        send(8'h13, 3'd0, 2'd0, 5'd0, 11'h000, 11'h000, 1'b0);
        send(8'h12, 3'd7, 2'd1, 5'd16, 11'h155, 11'h2AA, 1'b1);
        expect_cnt("R2 other code ignored", 3);
    endtask

    task automatic t_core;
        setup(mk_ctrl(8'h20, 6'b000001), mk_filt(8'h03, 0, 0, 0), 0, 0);
        send(8'h20, 3'd0, 2'd0, 0, 0, 0, 0);
        send(8'h20, 3'd1, 2'd0, 0, 0, 0, 0);
        send(8'h20, 3'd2, 2'd0, 0, 0, 0, 0);
        send(8'h20, 3'd7, 2'd0, 0, 0, 0, 0);
        expect_cnt("R3 core bitmap 0x3", 2);
    endtask

    task automatic t_req;
        setup(mk_ctrl(8'h21, 6'b000010), mk_filt(0, 3'b101, 0, 0), 0, 0);
        send(8'h21, 0, 2'd0, 0, 0, 0, 0);
        send(8'h21, 0, 2'd1, 0, 0, 0, 0);
        send(8'h21, 0, 2'd1, 0, 0, 0, 0);
        send(8'h21, 0, 2'd2, 0, 0, 0, 0);
        expect_cnt("R4 writes only", 2);
        setup(mk_ctrl(8'h21, 6'b000010), mk_filt(0, 3'b110, 0, 0), 0, 0);
        send(8'h21, 0, 2'd2, 0, 0, 0, 0);
        send(8'h21, 0, 2'd3, 0, 0, 0, 0);
        expect_cnt("R4 atomic store only", 1);
        setup(mk_ctrl(8'h21, 6'b000010), mk_filt(0, 3'b001, 0, 0), 0, 0);
        send(8'h21, 0, 2'd1, 0, 0, 0, 0);
        send(8'h21, 0, 2'd0, 0, 0, 0, 0);
        expect_cnt("R4 reserved code matches nothing", 0);
        setup(mk_ctrl(8'h21, 6'b0), mk_filt(0, 3'b100, 0, 0), 0, 0);
        for (int k = 0; k < 4; k++) send(8'h21, 0, 2'(k), 0, 0, 0, 0);
        expect_cnt("R4 disabled counts all kinds", 4);
    endtask

    task automatic t_dsrc;
        setup(mk_ctrl(8'h22, 6'b000100), mk_filt(0, 0, 5'b01110, 0), 0, 0);
        send(8'h22, 0, 0, 5'b01110, 0, 0, 0);
        send(8'h22, 0, 0, 5'b01111, 0, 0, 0);
        send(8'h22, 0, 0, 5'b00001, 0, 0, 0);
        expect_cnt("R5 data source exact", 1);
    endtask

    task automatic t_ids;
        // super-cluster 5, cluster bits masked
        setup(mk_ctrl(8'h23, 6'b001000), 0, {5'd0, 11'h01F, 5'd0, 11'h0A5}, 0);
        send(8'h23, 0, 0, 0, 11'h0A0, 11'h7FF, 0);
        send(8'h23, 0, 0, 0, 11'h0BF, 11'h000, 0);
        send(8'h23, 0, 0, 0, 11'h0C5, 11'h000, 0);
        expect_cnt("R6 masked source id", 2);
        setup(mk_ctrl(8'h23, 6'b010000), 0, 0, {5'd0, 11'h000, 5'd0, 11'h123});
        send(8'h23, 0, 0, 0, 11'h7FF, 11'h123, 0);
        send(8'h23, 0, 0, 0, 11'h000, 11'h122, 0);
        expect_cnt("R7 exact target id", 1);
    endtask

    task automatic t_chan;
        setup(mk_ctrl(8'h50, 6'b100000), mk_filt(0, 0, 0, 2'b10), 0, 0);
        send(8'h50, 0, 0, 0, 0, 0, 1'b0);
        send(8'h50, 0, 0, 0, 0, 0, 1'b1);
        expect_cnt("R8 normal ring only", 1);
        setup(mk_ctrl(8'h50, 6'b100000), mk_filt(0, 0, 0, 2'b01), 0, 0);
        send(8'h50, 0, 0, 0, 0, 0, 1'b1);
        send(8'h50, 0, 0, 0, 0, 0, 1'b0);
        expect_cnt("R8 select 01 extended only", 1);
        setup(mk_ctrl(8'h50, 6'b100000), mk_filt(0, 0, 0, 2'b11), 0, 0);
        send(8'h50, 0, 0, 0, 0, 0, 1'b0);
        expect_cnt("R8 select 11 rejects normal", 0);
        setup(mk_ctrl(8'h50, 6'b100000), mk_filt(0, 0, 0, 2'b00), 0, 0);
        send(8'h50, 0, 0, 0, 0, 0, 1'b0);
        send(8'h50, 0, 0, 0, 0, 0, 1'b1);
        expect_cnt("R8 select 00 both", 2);
    endtask

    task automatic t_chan_range;
        setup(mk_ctrl(8'h47, 6'b100000), mk_filt(0, 0, 0, 2'b10), 0, 0);
        send(8'h47, 0, 0, 0, 0, 0, 1'b1);
        expect_cnt("R9 code 0x47 filtered", 0);
        setup(mk_ctrl(8'h59, 6'b100000), mk_filt(0, 0, 0, 2'b10), 0, 0);
        send(8'h59, 0, 0, 0, 0, 0, 1'b1);
        expect_cnt("R9 code 0x59 filtered", 0);
        setup(mk_ctrl(8'h46, 6'b100000), mk_filt(0, 0, 0, 2'b10), 0, 0);
        send(8'h46, 0, 0, 0, 0, 0, 1'b1);
        expect_cnt("R9 code 0x46 unaffected", 1);
        setup(mk_ctrl(8'h5A, 6'b100000), mk_filt(0, 0, 0, 2'b10), 0, 0);
        send(8'h5A, 0, 0, 0, 0, 0, 1'b1);
        expect_cnt("R9 code 0x5A unaffected", 1);
    endtask

    task automatic t_and;
        setup(mk_ctrl(8'h30, 6'b000101), mk_filt(8'h01, 0, 5'b00001, 0), 0, 0);
        send(8'h30, 3'd0, 0, 5'b00001, 0, 0, 0);
        send(8'h30, 3'd0, 0, 5'b00010, 0, 0, 0);
        send(8'h30, 3'd1, 0, 5'b00001, 0, 0, 0);
        @(negedge clk);
        ev_valid = 1'b0; ev_code = 8'h30; ev_core = 0; ev_dsrc = 5'b00001;
        @(negedge clk);
        expect_cnt("R10 all enabled qualifiers ANDed", 1);
    endtask

    task automatic t_clear;
        logic [RW-1:0] v;
        setup(mk_ctrl(8'h31, 6'b0), 0, 0, 0);
        send(8'h31, 0, 0, 0, 0, 0, 0);
        send(8'h31, 0, 0, 0, 0, 0, 0);
        rd(A_CNTHI, v); chk("R11 high word small count", v, 0);
        @(negedge clk);
        ev_valid = 1'b1; ev_code = 8'h31;
        reg_we = 1'b1; reg_addr = A_CNTLO; reg_wdata = 0;
        @(negedge clk);
        ev_valid = 1'b0; reg_we = 1'b0;
        expect_cnt("R11 clear wins over event", 0);
    endtask

    task automatic t_overflow;
        logic [RW-1:0] v;
        setup(mk_ctrl(8'h40, 6'b0), 0, 0, 0);
        @(negedge clk);
        ev_valid = 1'b1; ev_code = 8'h40;
        repeat ((1 << SMALL_W) - 1) @(negedge clk);
        ev_valid = 1'b0;
        rd_s(A_CNTLO, v); chk("R12 narrow all ones", v, (1 << SMALL_W) - 1);
        chk("R12 no irq before wrap", irq_s, 0);
        send(8'h40, 0, 0, 0, 0, 0, 0);
        rd_s(A_CNTLO, v); chk("R12 wrapped to zero", v, 0);
        rd_s(A_STAT, v);  chk("R12 flag set", v, 1);
        chk("R12 irq raised", irq_s, 1);
        rd(A_CNTLO, v);   chk("R11 wide counter no wrap", v, 1 << SMALL_W);
        chk("R12 wide irq low", irq, 0);
        send(8'h40, 0, 0, 0, 0, 0, 0);
        chk("R12 irq sticky", irq_s, 1);
        wr(A_STAT, 32'h0);
        chk("R12 write of 0 keeps flag", irq_s, 1);
        wr(A_STAT, 32'h1);
        rd_s(A_STAT, v); chk("R12 flag cleared", v, 0);
        chk("R12 irq cleared", irq_s, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_core();
        t_req();
        t_dsrc();
        t_ids();
        t_chan();
        t_chan_range();
        t_and();
        t_clear();
        t_overflow();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end

endmodule